// File: doc/BRIEF.md
# Translation Unit Control Register File

This block is the software-facing control and status front end of an address-translation unit. A processor reaches it over a simple 32-bit register bus with a one-cycle read latency. Through it, software loads the base address of the first-level translation table, issues write-only commands that turn address translation on and off, requests and releases a stall of the translation datapath, flushes the translation cache, acknowledges page faults and forces the whole register file back to its reset state.

Towards the translation datapath the block drives a paging-enable level, a stall request and two flush strobes, one for the whole cache and one for a single page address. It receives a stall acknowledge, idle and replay-buffer-empty levels, a page-fault event with its virtual address and direction, and a bus-error event. Faults and bus errors are latched in a two-bit raw interrupt group with a mask. A level interrupt output is high whenever a masked bit is set.

The mode state machine has four states. BYPASS means translation is off. XLATE means translation is on. STALL_REQ means translation is on and a stall has been requested but not yet acknowledged. HALTED means translation is on and the datapath has acknowledged the stall. The transitions are as follows:
- enable-paging moves BYPASS to XLATE.
- enable-stall moves XLATE to STALL_REQ.
- the acknowledge input moves STALL_REQ to HALTED.
- disable-stall moves STALL_REQ or HALTED back to XLATE.
- disable-paging moves any state to BYPASS.
- force-reset moves any state to BYPASS, and it overrides everything else.

Top module: `xlat_ctl_regs`

## Requirements
- R1: After reset every readable register returns 0, with one exception. The status word returns bit 31 set, bit 3 equal to the idle input and bit 4 equal to the replay-empty input. The irq, paging-enable and stall-request outputs are low, and each read answers with bus_rvalid high one cycle after the request.
- R2: The table base register at offset 0x00 stores only bits 31:12 of a write, so a write of 0xCAFEBABE reads back as 0xCAFEB000.
- R3: Writing code 0 to the command register at 0x08 turns translation on: xl_paging_en and status bit 0 are high from the next cycle. Code 1 turns it off.
- R4: Code 2, issued while translation is on, raises xl_stall_req in the next cycle. Status bit 2 (stall active) becomes 1, and bit 31 (its inverse) becomes 0, only after xl_stall_ack is seen. Code 3 drops the request and clears bit 2.
- R5: Code 2 issued while translation is off has no effect: xl_stall_req stays low and status bit 2 stays 0.
- R6: Code 1 issued while stalled clears both translation and the stall in the next cycle.
- R7: A fault event while translation is on and no fault is pending has four effects: it sets status bit 1 (fault active), copies the write flag to status bit 5, stores the address in the fault register at 0x0C and sets raw interrupt bit 0. Further fault events while one is pending change none of these.
- R8: Code 5 (fault done) clears status bits 1 and 5. The raw interrupt bit remains set.
- R9: A bus-error event sets raw bit 1 (offset 0x14). The masked status at 0x20 equals raw AND the mask at 0x1C, and irq is high exactly when the masked status is non-zero. Writing ones to 0x18 clears those raw bits.
- R10: Code 4 gives a one-cycle xl_flush_all pulse in the cycle after the write. A write to 0x10 gives a one-cycle xl_flush_one pulse, with xl_flush_va equal to the written value with bits 11:0 cleared.
- R11: Code 6 (force reset) returns every register and the mode to reset values, so the base register reads 0, the mask and raw bits read 0 and irq is low.
- R12: The following have no effect: reads of 0x24 or of any other unmapped offset (they return 0), writes to read-only offsets, and command codes 7 and above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| xl_paging_en | output | 1 | Translation enabled |
| xl_stall_req | output | 1 | Stall request to datapath |
| xl_stall_ack | input | 1 | Datapath has stalled |
| xl_idle | input | 1 | Datapath idle level |
| xl_replay_empty | input | 1 | Replay buffer empty level |
| xl_fault_evt | input | 1 | Page-fault event strobe |
| xl_fault_wr | input | 1 | Faulting access was a write |
| xl_fault_va | input | DATA_W | Faulting virtual address |
| xl_buserr_evt | input | 1 | Table-read bus error strobe |
| xl_flush_all | output | 1 | Flush entire translation cache |
| xl_flush_one | output | 1 | Flush one page entry |
| xl_flush_va | output | DATA_W | Page address for single flush |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets five corner cases, each with a distinct wrong behaviour.
- A stall request while translation is off: a design that does not gate on paging raises xl_stall_req and shows stall active.
- Status before the acknowledge arrives: a design that skips the STALL_REQ wait reports stall active too early.
- A second fault while one is pending: a design without this guard overwrites the captured address.
- The interplay of mask and clear: irq must follow only the masked bits.
- Force reset: a design that clears only the mode leaves the table base and the mask readable after the command.

Random command and event sequences are compared against a register-level model of the status word, the fault address and the interrupt group.

// File: rtl/xlat_ctl_pkg.sv
package xlat_ctl_pkg;

    // register byte offsets (software-visible layout)
    localparam int unsigned OFS_BASE    = 'h00;
    localparam int unsigned OFS_STATUS  = 'h04;
    localparam int unsigned OFS_CMD     = 'h08;
    localparam int unsigned OFS_FLTVA   = 'h0C;
    localparam int unsigned OFS_FLUSH1  = 'h10;
    localparam int unsigned OFS_RAW     = 'h14;
    localparam int unsigned OFS_CLR     = 'h18;
    localparam int unsigned OFS_MASK    = 'h1C;
    localparam int unsigned OFS_MSKD    = 'h20;

    // command codes
    localparam int unsigned CMD_PG_ON   = 0;
    localparam int unsigned CMD_PG_OFF  = 1;
    localparam int unsigned CMD_ST_ON   = 2;
    localparam int unsigned CMD_ST_OFF  = 3;
    localparam int unsigned CMD_FLUSH   = 4;
    localparam int unsigned CMD_FDONE   = 5;
    localparam int unsigned CMD_SRST    = 6;

    // interrupt bit positions
    localparam int unsigned IRQ_FAULT   = 0;
    localparam int unsigned IRQ_BUSERR  = 1;

    typedef enum logic [1:0] {
        MS_BYPASS    = 2'd0,
        MS_XLATE     = 2'd1,
        MS_STALL_REQ = 2'd2,
        MS_HALTED    = 2'd3
    } mode_e;

    typedef struct packed {
        logic pg_on;
        logic pg_off;
        logic st_on;
        logic st_off;
        logic flush_all;
        logic fault_done;
        logic soft_rst;
    } cmd_t;

endpackage

// File: rtl/xlat_cmd_decode.sv
module xlat_cmd_decode
    import xlat_ctl_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] cmd_code,
    output cmd_t              cmd
);

    always_comb begin
        cmd = '0;
        if (cmd_wr) begin
            unique case (cmd_code)
                DATA_W'(CMD_PG_ON):  cmd.pg_on      = 1'b1;
                DATA_W'(CMD_PG_OFF): cmd.pg_off     = 1'b1;
                DATA_W'(CMD_ST_ON):  cmd.st_on      = 1'b1;
                DATA_W'(CMD_ST_OFF): cmd.st_off     = 1'b1;
                DATA_W'(CMD_FLUSH):  cmd.flush_all  = 1'b1;
                DATA_W'(CMD_FDONE):  cmd.fault_done = 1'b1;
                DATA_W'(CMD_SRST):   cmd.soft_rst   = 1'b1;
                default:             cmd            = '0;
            endcase
        end
    end

endmodule

// File: rtl/xlat_mode_fsm.sv
module xlat_mode_fsm
    import xlat_ctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  cmd_t  cmd,
    input  logic  stall_ack,
    output mode_e mode,
    output logic  paging_en,
    output logic  stall_req,
    output logic  stall_active
);

    mode_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MS_BYPASS;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (cmd.soft_rst) begin
            state_d = MS_BYPASS;
        end else begin
            unique case (state_q)
                MS_BYPASS: begin
                    if (cmd.pg_on) state_d = MS_XLATE;
                end
                MS_XLATE: begin
                    if (cmd.pg_off)     state_d = MS_BYPASS;
                    else if (cmd.st_on) state_d = MS_STALL_REQ;
                end
                MS_STALL_REQ: begin
                    if (cmd.pg_off)      state_d = MS_BYPASS;
                    else if (cmd.st_off) state_d = MS_XLATE;
                    else if (stall_ack)  state_d = MS_HALTED;
                end
                MS_HALTED: begin
                    if (cmd.pg_off)      state_d = MS_BYPASS;
                    else if (cmd.st_off) state_d = MS_XLATE;
                end
                default: state_d = MS_BYPASS;
            endcase
        end
    end

    always_comb begin
        mode         = state_q;
        paging_en    = 1'b0;
        stall_req    = 1'b0;
        stall_active = 1'b0;
        unique case (state_q)
            MS_BYPASS: ;
            MS_XLATE:  paging_en = 1'b1;
            MS_STALL_REQ: begin
                paging_en = 1'b1;
                stall_req = 1'b1;
            end
            MS_HALTED: begin
                paging_en    = 1'b1;
                stall_req    = 1'b1;
                stall_active = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/xlat_fault_track.sv
module xlat_fault_track #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              fault_done,
    input  logic              paging_en,
    input  logic              evt,
    input  logic              evt_wr,
    input  logic [DATA_W-1:0] evt_va,
    output logic              active,
    output logic              is_write,
    output logic [DATA_W-1:0] va,
    output logic              capture
);

    assign capture = evt && paging_en && !active && !soft_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active   <= 1'b0;
            is_write <= 1'b0;
            va       <= '0;
        end else if (soft_rst) begin
            active   <= 1'b0;
            is_write <= 1'b0;
            va       <= '0;
        end else if (capture) begin
            active   <= 1'b1;
            is_write <= evt_wr;
            va       <= evt_va;
        end else if (fault_done) begin
            active   <= 1'b0;
            is_write <= 1'b0;
        end
    end

endmodule

// File: rtl/xlat_irq_group.sv
module xlat_irq_group #(
    parameter int unsigned IRQ_N  = 2,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [IRQ_N-1:0]  set,
    input  logic              clr_wr,
    input  logic              mask_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [IRQ_N-1:0]  raw,
    output logic [IRQ_N-1:0]  mask,
    output logic [IRQ_N-1:0]  masked,
    output logic              irq
);

    for (genvar i = 0; i < IRQ_N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     raw[i] <= 1'b0;
            else if (soft_rst)              raw[i] <= 1'b0;
            else if (set[i])                raw[i] <= 1'b1;
            else if (clr_wr && wdata[i])    raw[i] <= 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        mask[i] <= 1'b0;
            else if (soft_rst) mask[i] <= 1'b0;
            else if (mask_wr)  mask[i] <= wdata[i];
        end
    end

    assign masked = raw & mask;
    assign irq    = |masked;

endmodule

// File: rtl/xlat_ctl_regs.sv
module xlat_ctl_regs
    import xlat_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned IRQ_N      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              xl_paging_en,
    output logic              xl_stall_req,
    input  logic              xl_stall_ack,
    input  logic              xl_idle,
    input  logic              xl_replay_empty,
    input  logic              xl_fault_evt,
    input  logic              xl_fault_wr,
    input  logic [DATA_W-1:0] xl_fault_va,
    input  logic              xl_buserr_evt,
    output logic              xl_flush_all,
    output logic              xl_flush_one,
    output logic [DATA_W-1:0] xl_flush_va,
    output logic              irq
);

    localparam logic [DATA_W-1:0] PAGE_MASK = ~((DATA_W'(1) << PAGE_SHIFT) - DATA_W'(1));

    logic wr_en, rd_en;
    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    logic hit_base, hit_cmd, hit_fl1, hit_clr, hit_mask;
    assign hit_base = wr_en && (bus_addr == ADDR_W'(OFS_BASE));
    assign hit_cmd  = wr_en && (bus_addr == ADDR_W'(OFS_CMD));
    assign hit_fl1  = wr_en && (bus_addr == ADDR_W'(OFS_FLUSH1));
    assign hit_clr  = wr_en && (bus_addr == ADDR_W'(OFS_CLR));
    assign hit_mask = wr_en && (bus_addr == ADDR_W'(OFS_MASK));

    cmd_t cmd;
    xlat_cmd_decode #(.DATA_W(DATA_W)) u_dec (
        .cmd_wr   (hit_cmd),
        .cmd_code (bus_wdata),
        .cmd      (cmd)
    );

    mode_e mode;
    logic  stall_active;
    xlat_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd          (cmd),
        .stall_ack    (xl_stall_ack),
        .mode         (mode),
        .paging_en    (xl_paging_en),
        .stall_req    (xl_stall_req),
        .stall_active (stall_active)
    );

    logic              flt_active, flt_write, flt_capture;
    logic [DATA_W-1:0] flt_va;
    xlat_fault_track #(.DATA_W(DATA_W)) u_flt (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (cmd.soft_rst),
        .fault_done (cmd.fault_done),
        .paging_en  (xl_paging_en),
        .evt        (xl_fault_evt),
        .evt_wr     (xl_fault_wr),
        .evt_va     (xl_fault_va),
        .active     (flt_active),
        .is_write   (flt_write),
        .va         (flt_va),
        .capture    (flt_capture)
    );

    logic [IRQ_N-1:0] irq_set, irq_raw, irq_mask, irq_masked;
    always_comb begin
        irq_set             = '0;
        irq_set[IRQ_FAULT]  = flt_capture;
        irq_set[IRQ_BUSERR] = xl_buserr_evt;
    end

    xlat_irq_group #(.IRQ_N(IRQ_N), .DATA_W(DATA_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (cmd.soft_rst),
        .set      (irq_set),
        .clr_wr   (hit_clr),
        .mask_wr  (hit_mask),
        .wdata    (bus_wdata),
        .raw      (irq_raw),
        .mask     (irq_mask),
        .masked   (irq_masked),
        .irq      (irq)
    );

    logic [DATA_W-1:0] base_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        base_q <= '0;
        else if (cmd.soft_rst) base_q <= '0;
        else if (hit_base) base_q <= bus_wdata & PAGE_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xl_flush_all <= 1'b0;
            xl_flush_one <= 1'b0;
            xl_flush_va  <= '0;
        end else begin
            xl_flush_all <= cmd.flush_all;
            xl_flush_one <= hit_fl1;
            if (hit_fl1) xl_flush_va <= bus_wdata & PAGE_MASK;
        end
    end

    logic [DATA_W-1:0] status_w;
    always_comb begin
        status_w           = '0;
        status_w[0]        = xl_paging_en;
        status_w[1]        = flt_active;
        status_w[2]        = stall_active;
        status_w[3]        = xl_idle;
        status_w[4]        = xl_replay_empty;
        status_w[5]        = flt_write;
        status_w[DATA_W-1] = !stall_active;
    end

    logic [DATA_W-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            ADDR_W'(OFS_BASE):   rd_mux = base_q;
            ADDR_W'(OFS_STATUS): rd_mux = status_w;
            ADDR_W'(OFS_FLTVA):  rd_mux = flt_va;
            ADDR_W'(OFS_RAW):    rd_mux = DATA_W'(irq_raw);
            ADDR_W'(OFS_MASK):   rd_mux = DATA_W'(irq_mask);
            ADDR_W'(OFS_MSKD):   rd_mux = DATA_W'(irq_masked);
            default:             rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd_en;
            if (rd_en) bus_rdata <= rd_mux;
        end
    end

    logic unused_mode;
    assign unused_mode = ^mode;

endmodule

// File: rtl/xlat_ctl_chk.sv
module xlat_ctl_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              xl_paging_en,
    input logic              xl_stall_req,
    input logic              xl_flush_all,
    input logic              xl_flush_one,
    input logic              irq
);

    logic cmd_w;
    assign cmd_w = bus_sel && bus_wr && (bus_addr == ADDR_W'('h08));

    logic c_on, c_off, c_st, c_unst, c_fl, c_rst, w_fl1;
    assign c_on   = cmd_w && (bus_wdata == DATA_W'(0));
    assign c_off  = cmd_w && (bus_wdata == DATA_W'(1));
    assign c_st   = cmd_w && (bus_wdata == DATA_W'(2));
    assign c_unst = cmd_w && (bus_wdata == DATA_W'(3));
    assign c_fl   = cmd_w && (bus_wdata == DATA_W'(4));
    assign c_rst  = cmd_w && (bus_wdata == DATA_W'(6));
    assign w_fl1  = bus_sel && bus_wr && (bus_addr == ADDR_W'('h10));

    a_r3_enable_paging: assert property (@(posedge clk) disable iff (!rst_n)
        c_on |=> xl_paging_en);

    a_r4_stall_held: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_stall_req && !c_off && !c_unst && !c_rst) |=> xl_stall_req);

    a_r5_stall_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (c_st && !xl_paging_en) |=> !xl_stall_req);

    a_r6_disable_all: assert property (@(posedge clk) disable iff (!rst_n)
        c_off |=> (!xl_paging_en && !xl_stall_req));

    a_r10_flush_all_src: assert property (@(posedge clk) disable iff (!rst_n)
        xl_flush_all |-> $past(c_fl));

    a_r10_flush_one_src: assert property (@(posedge clk) disable iff (!rst_n)
        xl_flush_one |-> $past(w_fl1));

    a_r11_force_reset: assert property (@(posedge clk) disable iff (!rst_n)
        c_rst |=> (!xl_paging_en && !xl_stall_req && !irq));

endmodule

bind xlat_ctl_regs xlat_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .xl_paging_en (xl_paging_en),
    .xl_stall_req (xl_stall_req),
    .xl_flush_all (xl_flush_all),
    .xl_flush_one (xl_flush_one),
    .irq          (irq)
);

// File: tb/xlat_ctl_regs_tb_top.sv
module xlat_ctl_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        xl_paging_en, xl_stall_req;
    logic        xl_stall_ack = 1'b0, xl_idle = 1'b1, xl_replay_empty = 1'b1;
    logic        xl_fault_evt = 1'b0, xl_fault_wr = 1'b0, xl_buserr_evt = 1'b0;
    logic [31:0] xl_fault_va = '0;
    logic        xl_flush_all, xl_flush_one;
    logic [31:0] xl_flush_va;
    logic        irq;

    always #5 clk = ~clk;

    xlat_ctl_regs dut_i (.*);

    int total = 0;
    int bad   = 0;

    // bench model
    logic        m_pg, m_st, m_flt, m_fwr;
    logic [31:0] m_fva, m_base;
    logic [1:0]  m_raw, m_mask;

    function automatic logic [31:0] exp_status();
        return {~m_st, 25'd0, m_fwr, xl_replay_empty, xl_idle, m_st, m_flt, m_pg};
    endfunction

    function automatic logic exp_irq();
        return |(m_raw & m_mask);
    endfunction

    task automatic model_reset();
        m_pg = 0; m_st = 0; m_flt = 0; m_fwr = 0;
        m_fva = 0; m_base = 0; m_raw = 0; m_mask = 0;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        @(negedge clk);
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        d = bus_rdata;
    endtask

    task automatic fault_pulse(logic [31:0] va, logic w);
        @(negedge clk);
        xl_fault_evt = 1; xl_fault_va = va; xl_fault_wr = w;
        @(negedge clk);
        xl_fault_evt = 0;
        if (m_pg && !m_flt) begin
            m_flt = 1; m_fwr = w; m_fva = va; m_raw[0] = 1;
        end
    endtask

    task automatic buserr_pulse();
        @(negedge clk);
        xl_buserr_evt = 1;
        @(negedge clk);
        xl_buserr_evt = 0;
        m_raw[1] = 1;
    endtask

    task automatic model_cmd(int c);
        case (c)
            0: m_pg = 1;
            1: begin m_pg = 0; m_st = 0; end
            2: if (m_pg) m_st = 1;
            3: m_st = 0;
            5: begin m_flt = 0; m_fwr = 0; end
            6: model_reset();
            default: ;
        endcase
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        bus_read(8'h04, rd);
        check("R1 status", rd, 32'h8000_0018);
        check("R1 rvalid", {31'd0, bus_rvalid}, 32'd1);
        bus_read(8'h00, rd);
        check("R1 base", rd, 32'd0);
        check("R1 outputs", {29'd0, irq, xl_paging_en, xl_stall_req}, 32'd0);

        // R2 base masking
        bus_write(8'h00, 32'hCAFE_BABE);
        bus_read(8'h00, rd);
        check("R2 base", rd, 32'hCAFE_B000);

        // R5 stall ignored while off
        bus_write(8'h08, 32'd2);
        check("R5 stall_req", {31'd0, xl_stall_req}, 32'd0);
        bus_read(8'h04, rd);
        check("R5 status", rd, 32'h8000_0018);

        // R3 enable paging
        bus_write(8'h08, 32'd0);
        check("R3 paging_en", {31'd0, xl_paging_en}, 32'd1);
        bus_read(8'h04, rd);
        check("R3 status", rd, 32'h8000_0019);

        // R4 stall handshake
        bus_write(8'h08, 32'd2);
        check("R4 stall_req", {31'd0, xl_stall_req}, 32'd1);
        bus_read(8'h04, rd);
        check("R4 before ack", rd, 32'h8000_0019);
        xl_stall_ack = 1;
        repeat (2) @(negedge clk);
        bus_read(8'h04, rd);
        check("R4 after ack", rd, 32'h0000_001D);
        bus_write(8'h08, 32'd3);
        check("R4 unstall req", {31'd0, xl_stall_req}, 32'd0);
        bus_read(8'h04, rd);
        check("R4 unstall status", rd, 32'h8000_0019);

        // R6 disable paging while stalled
        bus_write(8'h08, 32'd2);
        bus_write(8'h08, 32'd1);
        check("R6 outputs", {30'd0, xl_paging_en, xl_stall_req}, 32'd0);
        bus_read(8'h04, rd);
        check("R6 status", rd, 32'h8000_0018);

        // R7 fault capture
        model_reset(); m_base = 32'hCAFE_B000;
        bus_write(8'h08, 32'd0); model_cmd(0);
        bus_write(8'h1C, 32'd3); m_mask = 3;
        fault_pulse(32'h1234_5678, 1'b1);
        bus_read(8'h04, rd);
        check("R7 status", rd, 32'h8000_003B);
        bus_read(8'h0C, rd);
        check("R7 address", rd, 32'h1234_5678);
        check("R7 irq", {31'd0, irq}, 32'd1);
        fault_pulse(32'h0BAD_0000, 1'b0);
        bus_read(8'h0C, rd);
        check("R7 address held", rd, 32'h1234_5678);

        // R8 fault done
        bus_write(8'h08, 32'd5);
        bus_read(8'h04, rd);
        check("R8 status", rd, 32'h8000_0019);
        bus_read(8'h14, rd);
        check("R8 raw kept", rd, 32'd1);

        // R9 interrupt group
        buserr_pulse();
        bus_read(8'h14, rd);
        check("R9 raw", rd, 32'd3);
        bus_write(8'h1C, 32'd1);
        bus_read(8'h20, rd);
        check("R9 masked", rd, 32'd1);
        bus_write(8'h18, 32'd1);
        bus_read(8'h14, rd);
        check("R9 cleared", rd, 32'd2);
        check("R9 irq low", {31'd0, irq}, 32'd0);

        // R10 flush strobes
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 8'h08; bus_wdata = 32'd4;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        check("R10 flush_all pulse", {31'd0, xl_flush_all}, 32'd1);
        @(negedge clk);
        check("R10 flush_all end", {31'd0, xl_flush_all}, 32'd0);
        bus_sel = 1; bus_wr = 1; bus_addr = 8'h10; bus_wdata = 32'hABCD_E123;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        check("R10 flush_one", {31'd0, xl_flush_one}, 32'd1);
        check("R10 flush_va", xl_flush_va, 32'hABCD_E000);
        @(negedge clk);
        check("R10 flush_one end", {31'd0, xl_flush_one}, 32'd0);

        // R12 unmapped and ignored writes
        bus_read(8'h24, rd);
        check("R12 offset 0x24", rd, 32'd0);
        bus_read(8'h40, rd);
        check("R12 offset 0x40", rd, 32'd0);
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h08, 32'd7);
        bus_read(8'h04, rd);
        check("R12 status unchanged", rd, 32'h8000_0019);

        // R11 force reset
        bus_write(8'h1C, 32'd3);
        bus_write(8'h08, 32'd6);
        bus_read(8'h00, rd);
        check("R11 base", rd, 32'd0);
        bus_read(8'h1C, rd);
        check("R11 mask", rd, 32'd0);
        bus_read(8'h14, rd);
        check("R11 raw", rd, 32'd0);
        bus_read(8'h04, rd);
        check("R11 status", rd, 32'h8000_0018);
        check("R11 irq", {31'd0, irq}, 32'd0);
        model_reset();

        // random phase, datapath acknowledges stalls at once
        void'($urandom(32'h5EED_1234));
        xl_stall_ack = 1;
        for (int n = 0; n < 500; n++) begin
            int op;
            op = $urandom_range(0, 7);
            case (op)
                0, 1: begin
                    int c;
                    c = $urandom_range(0, 7);
                    bus_write(8'h08, 32'(c));
                    model_cmd(c);
                end
                2: begin
                    logic [31:0] d;
                    d = $urandom();
                    bus_write(8'h00, d);
                    m_base = d & 32'hFFFF_F000;
                end
                3: begin
                    logic [1:0] d;
                    d = 2'($urandom_range(0, 3));
                    bus_write(8'h1C, {30'd0, d});
                    m_mask = d;
                end
                4: begin
                    logic [1:0] d;
                    d = 2'($urandom_range(0, 3));
                    bus_write(8'h18, {30'd0, d});
                    m_raw = m_raw & ~d;
                end
                5: fault_pulse($urandom(), 1'($urandom_range(0, 1)));
                6: buserr_pulse();
                default: begin
                    bus_read(8'h04, rd);
                    check("R3 R4 R7 rand status", rd, exp_status());
                    bus_read(8'h0C, rd);
                    check("R7 rand fault va", rd, m_fva);
                    bus_read(8'h00, rd);
                    check("R2 R11 rand base", rd, m_base);
                    bus_read(8'h20, rd);
                    check("R9 rand masked", rd, {30'd0, m_raw & m_mask});
                    check("R9 rand irq", {31'd0, irq}, {31'd0, exp_irq()});
                end
            endcase
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule